// File: doc/BRIEF.md
# GPIO Port with Per-Line Routed Interrupts

This block is a memory-mapped general-purpose I/O port of up to 32 lines on a simple 32-bit register bus. Each line has a synchronised input sample, an output value and a direction bit. The line count is a parameter. The pad side is exposed as separate output-value and output-enable vectors, and the pad cell that combines them lives outside the block.

Each line can raise an interrupt. The interrupt is enabled per line, and its trigger is set per line as level-low, level-high, falling-edge or rising-edge. A routing table held in registers sends each line's interrupt to one of several shared interrupt outputs, or to none. Each interrupt output is the OR of every enabled line routed to it. Software programs the trigger type and the routing first, and then sets the enable bit.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every writable register reads zero, `pin_oe` is all zero and `irq_out` is all zero.
- R2: Word offsets are output value 0x04, direction 0x08, enable 0x0C, polarity 0x10 and edge select 0x14. A write takes effect at the next clock edge. `bus_rdata` follows `bus_addr` in the same cycle. Bits at or above `N_LINES` read as zero. A read of an unmapped or misaligned address (`bus_addr[1:0]` not 0) returns zero, and a write to such an address changes nothing.
- R3: Offset 0x00 returns the pin inputs after a two-flop synchroniser, so a pin change shows there two clock edges later. A write to 0x00 changes no register.
- R4: `pin_oe` equals the direction register (1 = drive) and `pin_out` equals the output-value register.
- R5: With edge-select 0, a line is active while its synchronised level equals its polarity bit (0 = low, 1 = high). The routed output stays high for as long as that level persists.
- R6: With edge-select 1, polarity 1 selects rising edges and polarity 0 selects falling edges. An edge is found by comparing the current synchronised sample with the previous one, and it gives a pulse of exactly one clock on the routed output.
- R7: A line contributes to an interrupt output only while its enable bit is 1. Clearing the bit removes its contribution in the cycle right after the write edge.
- R8: The routing table starts at 0x20 and holds one 8-bit field per line, four fields per word, with line 4w+j in bits [8j+7:8j] of word w. Fields of lines at or above `N_LINES` read as zero. A field value k below `N_IRQ` sends the line to `irq_out[k]`, and several lines may share one output.
- R9: A routing field value at or above `N_IRQ` leaves the line unrouted, and that line never drives any interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | N_LINES | Pin input levels |
| pin_out | output | N_LINES | Output values toward pads |
| pin_oe | output | N_LINES | Output enables toward pads |
| irq_out | output | N_IRQ | Shared interrupt outputs |

## Verification
The assertions watch on every cycle that direction writes land on the next edge, that a write to the data offset leaves the other registers alone, that a disabled or fully unrouted set of lines keeps every interrupt output low, that an edge hit never lasts two cycles under a steady polarity, and that the block is quiet when reset is released. Only the bench's scenarios can show the two-cycle synchroniser latency, that level interrupts persist, the exact single-cycle edge pulse for each polarity, the sharing of one output by two lines, and the packing of the routing fields. A behavioural model in the bench runs alongside for the whole run and compares the read data, the pad outputs and the interrupts on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned MAX_LINES  = 32;
    localparam int unsigned ROUTE_W    = 8;
    localparam int unsigned FIELDS_PER_WORD = 32 / ROUTE_W;

    // word indices of the register map (byte offset / 4)
    localparam int unsigned W_DATA   = 0;
    localparam int unsigned W_OUT    = 1;
    localparam int unsigned W_DIR    = 2;
    localparam int unsigned W_MASK   = 3;
    localparam int unsigned W_POL    = 4;
    localparam int unsigned W_EDGE   = 5;
    localparam int unsigned W_ROUTE0 = 8;

    function automatic int unsigned route_words(input int unsigned n);
        return (n + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.s1   = din;
        s_d.s2   = s_q.s1;
        s_d.prev = s_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_o  = s_q.s2;
    assign prev_o = s_q.prev;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [31:0]                       bus_wdata,
    output logic [31:0]                       bus_rdata,
    input  logic [N_LINES-1:0]                din,
    output logic [N_LINES-1:0]                out_o,
    output logic [N_LINES-1:0]                dir_o,
    output logic [N_LINES-1:0]                mask_o,
    output logic [N_LINES-1:0]                pol_o,
    output logic [N_LINES-1:0]                edg_o,
    output logic [N_LINES-1:0][ROUTE_W-1:0]   route_o
);
    localparam int unsigned WIDX_W   = ADDR_W - 2;
    localparam int unsigned RT_WORDS = route_words(N_LINES);
    localparam logic [WIDX_W-1:0] I_DATA = WIDX_W'(W_DATA);
    localparam logic [WIDX_W-1:0] I_OUT  = WIDX_W'(W_OUT);
    localparam logic [WIDX_W-1:0] I_DIR  = WIDX_W'(W_DIR);
    localparam logic [WIDX_W-1:0] I_MASK = WIDX_W'(W_MASK);
    localparam logic [WIDX_W-1:0] I_POL  = WIDX_W'(W_POL);
    localparam logic [WIDX_W-1:0] I_EDGE = WIDX_W'(W_EDGE);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(W_DATA * 4);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(W_DIR * 4);

    typedef struct packed {
        logic [N_LINES-1:0]              out;
        logic [N_LINES-1:0]              dir;
        logic [N_LINES-1:0]              mask;
        logic [N_LINES-1:0]              pol;
        logic [N_LINES-1:0]              edg;
        logic [N_LINES-1:0][ROUTE_W-1:0] route;
    } regs_t;

    regs_t r_d, r_q;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic              is_route;
    int unsigned       rword;
    logic              wr_hit;

    function automatic logic [31:0] ext(input logic [N_LINES-1:0] v);
        logic [31:0] r;
        r = '0;
        r[N_LINES-1:0] = v;
        return r;
    endfunction

    always_comb begin
        widx     = bus_addr[ADDR_W-1:2];
        aligned  = (bus_addr[1:0] == 2'b00);
        is_route = (int'(widx) >= int'(W_ROUTE0)) &&
                   (int'(widx) <  int'(W_ROUTE0 + RT_WORDS));
        rword    = int'(widx) - int'(W_ROUTE0);
        wr_hit   = bus_sel && bus_wr && aligned;
    end

    // next-state logic
    always_comb begin
        r_d = r_q;
        if (wr_hit) begin
            unique case (widx)
                I_OUT:  r_d.out  = bus_wdata[N_LINES-1:0];
                I_DIR:  r_d.dir  = bus_wdata[N_LINES-1:0];
                I_MASK: r_d.mask = bus_wdata[N_LINES-1:0];
                I_POL:  r_d.pol  = bus_wdata[N_LINES-1:0];
                I_EDGE: r_d.edg  = bus_wdata[N_LINES-1:0];
                default: begin
                    if (is_route) begin
                        for (int i = 0; i < int'(N_LINES); i++) begin
                            if (i / int'(FIELDS_PER_WORD) == int'(rword))
                                r_d.route[i] = bus_wdata[ROUTE_W*(i % int'(FIELDS_PER_WORD)) +: ROUTE_W];
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read path
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (widx)
                I_DATA: bus_rdata = ext(din);
                I_OUT:  bus_rdata = ext(r_q.out);
                I_DIR:  bus_rdata = ext(r_q.dir);
                I_MASK: bus_rdata = ext(r_q.mask);
                I_POL:  bus_rdata = ext(r_q.pol);
                I_EDGE: bus_rdata = ext(r_q.edg);
                default: begin
                    if (is_route) begin
                        for (int i = 0; i < int'(N_LINES); i++) begin
                            if (i / int'(FIELDS_PER_WORD) == int'(rword))
                                bus_rdata[ROUTE_W*(i % int'(FIELDS_PER_WORD)) +: ROUTE_W] = r_q.route[i];
                        end
                    end
                end
            endcase
        end
    end

    assign out_o   = r_q.out;
    assign dir_o   = r_q.dir;
    assign mask_o  = r_q.mask;
    assign pol_o   = r_q.pol;
    assign edg_o   = r_q.edg;
    assign route_o = r_q.route;

    AST_DIR_WRITE_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_DIR) |=> (dir_o == $past(bus_wdata[N_LINES-1:0]))); // R2

    AST_DATA_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_DATA) |=>
        ($stable(out_o) && $stable(dir_o) && $stable(mask_o) &&
         $stable(pol_o) && $stable(edg_o) && $stable(route_o))); // R3
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned N_IRQ   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_LINES-1:0]                cur_i,
    input  logic [N_LINES-1:0]                prev_i,
    input  logic [N_LINES-1:0]                mask_i,
    input  logic [N_LINES-1:0]                pol_i,
    input  logic [N_LINES-1:0]                edg_i,
    input  logic [N_LINES-1:0][ROUTE_W-1:0]   route_i,
    output logic [N_IRQ-1:0]                  irq_o
);
    logic [N_LINES-1:0] level_hit;
    logic [N_LINES-1:0] edge_hit;
    logic [N_LINES-1:0] line_hit;
    logic [N_LINES-1:0] unrouted;

    always_comb begin
        for (int i = 0; i < int'(N_LINES); i++) begin
            level_hit[i] = pol_i[i] ? cur_i[i] : ~cur_i[i];
            edge_hit[i]  = pol_i[i] ? (cur_i[i] & ~prev_i[i]) : (~cur_i[i] & prev_i[i]);
            line_hit[i]  = mask_i[i] & (edg_i[i] ? edge_hit[i] : level_hit[i]);
            unrouted[i]  = (int'(route_i[i]) >= int'(N_IRQ));
        end
    end

    for (genvar k = 0; k < int'(N_IRQ); k++) begin : g_out
        logic [N_LINES-1:0] sel;
        always_comb begin
            for (int i = 0; i < int'(N_LINES); i++)
                sel[i] = (route_i[i] == ROUTE_W'(k));
        end
        assign irq_o[k] = |(line_hit & sel);
    end

    AST_MASK_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == '0) |-> (irq_o == '0)); // R7

    AST_UNROUTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&unrouted) |-> (irq_o == '0)); // R9

    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_hit & $past(edge_hit) & ~(pol_i ^ $past(pol_i))) == '0)); // R6
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned N_IRQ   = 4,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [N_LINES-1:0]   pin_in,
    output logic [N_LINES-1:0]   pin_out,
    output logic [N_LINES-1:0]   pin_oe,
    output logic [N_IRQ-1:0]     irq_out
);
    logic [N_LINES-1:0]              cur, prev;
    logic [N_LINES-1:0]              mask, pol, edg;
    logic [N_LINES-1:0][ROUTE_W-1:0] route;

    gpio_in_sync #(.W(N_LINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_in),
        .cur_o  (cur),
        .prev_o (prev)
    );

    gpio_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .din       (cur),
        .out_o     (pin_out),
        .dir_o     (pin_oe),
        .mask_o    (mask),
        .pol_o     (pol),
        .edg_o     (edg),
        .route_o   (route)
    );

    gpio_irq_route #(.N_LINES(N_LINES), .N_IRQ(N_IRQ)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur_i   (cur),
        .prev_i  (prev),
        .mask_i  (mask),
        .pol_i   (pol),
        .edg_i   (edg),
        .route_i (route),
        .irq_o   (irq_out)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && irq_out == '0)); // R1
endmodule

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/100ps
module tb_gpio_irq_port;
    localparam int NL = 12;
    localparam int NI = 3;
    localparam int AW = 8;
    localparam logic [31:0] LMASK = 32'h0000_0FFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out, pin_oe;
    logic [NI-1:0] irq_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    gpio_irq_port #(.N_LINES(NL), .N_IRQ(NI), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // behavioural reference model
    logic [31:0] m_out, m_dir, m_mask, m_pol, m_edg, m_s1, m_s2, m_prev;
    int          m_route [32];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_out = 0; m_dir = 0; m_mask = 0; m_pol = 0; m_edg = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
            for (int i = 0; i < 32; i++) m_route[i] = 0;
        end else begin
            if (bus_sel && bus_wr && bus_addr[1:0] == 2'b00) begin
                int w;
                w = int'(bus_addr) / 4;
                if (w == 1) m_out = bus_wdata & LMASK;
                else if (w == 2) m_dir = bus_wdata & LMASK;
                else if (w == 3) m_mask = bus_wdata & LMASK;
                else if (w == 4) m_pol = bus_wdata & LMASK;
                else if (w == 5) m_edg = bus_wdata & LMASK;
                else if (w >= 8) begin
                    for (int j = 0; j < 4; j++) begin
                        int li;
                        li = (w - 8) * 4 + j;
                        if (li < NL) m_route[li] = int'((bus_wdata >> (8 * j)) & 32'hFF);
                    end
                end
            end
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = 32'(pin_in);
        end
    end

    function automatic logic [NI-1:0] model_irq();
        logic [NI-1:0] r;
        r = '0;
        for (int k = 0; k < NI; k++)
            for (int i = 0; i < NL; i++)
                if (m_mask[i] && m_route[i] == k) begin
                    bit act;
                    if (m_edg[i]) act = m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
                    else          act = m_pol[i] ? m_s2[i] : !m_s2[i];
                    if (act) r[k] = 1'b1;
                end
        return r;
    endfunction

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        int w;
        logic [31:0] r;
        r = 0;
        w = int'(a) / 4;
        if (a[1:0] != 2'b00) return 0;
        if (w == 0) r = m_s2 & LMASK;
        else if (w == 1) r = m_out;
        else if (w == 2) r = m_dir;
        else if (w == 3) r = m_mask;
        else if (w == 4) r = m_pol;
        else if (w == 5) r = m_edg;
        else if (w >= 8)
            for (int j = 0; j < 4; j++) begin
                int li;
                li = (w - 8) * 4 + j;
                if (li < NL) r = r | (32'(m_route[li]) << (8 * j));
            end
        return r;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            logic [NI-1:0] ei;
            logic [31:0] er;
            ei = model_irq();
            er = model_read(bus_addr);
            n_checks++;
            if (irq_out !== ei || bus_rdata !== er ||
                pin_out !== m_out[NL-1:0] || pin_oe !== m_dir[NL-1:0]) begin
                n_fail++;
                $display("FAIL %s model: irq=%h/%h rdata=%h/%h out=%h/%h oe=%h/%h (actual/expected)",
                         cur_req, irq_out, ei, bus_rdata, er, pin_out, m_out[NL-1:0], pin_oe, m_dir[NL-1:0]);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 chk(req, bus_rdata, exp);
        bus_sel = 0;
    endtask

    task automatic set_pins(input logic [NL-1:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_irq(input int k, input int cycles, output int cnt);
        cnt = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            #1;
            if (irq_out[k]) cnt++;
        end
    endtask

    initial begin
        int cnt;
        idle(3);
        rst_n = 1;
        @(negedge clk); #1;
        // R1: reset state
        cur_req = "R1";
        chk("R1 oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(irq_out), 0);
        rd_chk("R1 out", 8'h04, 0);
        rd_chk("R1 dir", 8'h08, 0);
        rd_chk("R1 mask", 8'h0C, 0);
        rd_chk("R1 route", 8'h20, 0);

        // R2: write/read, upper bits zero, misaligned
        cur_req = "R2";
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R2 out upper bits", 8'h04, 32'h0000_0FFF);
        wr(8'h05, 32'h0000_0000);
        rd_chk("R2 misaligned write", 8'h04, 32'h0000_0FFF);
        rd_chk("R2 misaligned read", 8'h05, 0);
        rd_chk("R2 unmapped", 8'h18, 0);

        // R4: direction drives pins
        cur_req = "R4";
        wr(8'h08, 32'h0000_00F0);
        #1 chk("R4 oe", 32'(pin_oe), 32'h0F0);
        chk("R4 out", 32'(pin_out), 32'hFFF);

        // R3: synchroniser latency and ignored data write
        cur_req = "R3";
        @(negedge clk);
        pin_in = 12'hA5A;
        bus_addr = 8'h00;
        @(negedge clk); #1 chk("R3 one edge", bus_rdata, 0);
        @(negedge clk); #1 chk("R3 two edges", bus_rdata, 32'hA5A);
        wr(8'h00, 32'h0000_0123);
        rd_chk("R3 data write ignored", 8'h00, 32'hA5A);
        rd_chk("R3 dir unchanged", 8'h08, 32'h0F0);

        // R8: routing table packing
        cur_req = "R8";
        wr(8'h20, 32'h0302_0100);
        wr(8'h24, 32'hFFFF_0202);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h2C, 32'h1111_1111);
        rd_chk("R8 word0", 8'h20, 32'h0302_0100);
        rd_chk("R8 word1", 8'h24, 32'hFFFF_0202);
        rd_chk("R8 word2", 8'h28, 32'hFFFF_FFFF);
        rd_chk("R8 beyond lines", 8'h2C, 0);

        // configure triggers, then enable
        cur_req = "R5";
        set_pins('0);
        wr(8'h10, 32'h0000_003B);   // pol: lines 0,1,3,4,5 high/rising
        wr(8'h14, 32'h0000_0002);   // edge select: line 1
        idle(3);
        wr(8'h0C, 32'h0000_003B);
        #1 chk("R5 quiet when inactive", 32'(irq_out), 0);

        // R5: level high persists
        set_pins(12'h001);
        idle(2);
        #1 chk("R5 level high", 32'(irq_out), 32'b001);
        idle(4);
        #1 chk("R5 level persists", 32'(irq_out), 32'b001);
        set_pins(12'h000);
        idle(2);
        #1 chk("R5 level released", 32'(irq_out), 0);
        wr(8'h10, 32'h0000_003A);   // line 0 now level low
        #1 chk("R5 level low", 32'(irq_out), 32'b001);

        // R6: rising edge on line 1 -> one pulse on irq 1
        cur_req = "R6";
        set_pins(12'h002);
        count_irq(1, 6, cnt);
        chk("R6 rising pulse count", 32'(cnt), 1);
        set_pins(12'h000);
        count_irq(1, 6, cnt);
        chk("R6 rising ignores fall", 32'(cnt), 0);
        wr(8'h10, 32'h0000_0038);   // line 1 falling
        set_pins(12'h002);
        count_irq(1, 6, cnt);
        chk("R6 falling ignores rise", 32'(cnt), 0);
        set_pins(12'h000);
        count_irq(1, 6, cnt);
        chk("R6 falling pulse count", 32'(cnt), 1);

        // R7: clearing the enable blocks at once
        cur_req = "R7";
        #1 chk("R7 before clear", 32'(irq_out[0]), 1);
        wr(8'h0C, 32'h0000_003A);
        #1 chk("R7 after clear", 32'(irq_out[0]), 0);

        // R8: two lines share irq 2
        cur_req = "R8";
        set_pins(12'h010);
        idle(2);
        #1 chk("R8 line4 to irq2", 32'(irq_out), 32'b100);
        set_pins(12'h020);
        idle(2);
        #1 chk("R8 line5 to irq2", 32'(irq_out), 32'b100);
        set_pins(12'h000);
        idle(2);

        // R9: unrouted line 3 (field 3) and line 6 (field 0xFF)
        cur_req = "R9";
        wr(8'h10, 32'h0000_0048);   // lines 3 and 6 level high
        wr(8'h0C, 32'h0000_0048);
        set_pins(12'h048);
        idle(3);
        #1 chk("R9 unrouted lines silent", 32'(irq_out), 0);
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule